// File: doc/BRIEF.md
# Trigger-Port Arithmetic Function Unit

This block is an arithmetic function unit meant to sit on the move buses of a processor whose instructions only transport data. It has three writable ports and one readable port. The plain operand port stores a word and does nothing more. Each operation has its own trigger port, one for add and one for multiply. A write to a trigger port starts that operation, and the operation combines the stored operand with the word being written. The result port shows the most recently completed result and keeps showing it until a later operation completes.

Each operation has a fixed latency that the program can see. An add is visible in the cycle right after the trigger. A multiply is visible in the third cycle after the trigger. The unit has no interlock, no hazard detection and no stall. A read made too early returns whatever completed before it. The multiplier is pipelined, so the unit accepts a trigger on every cycle. Bus routing and instruction decoding belong to the surrounding processor. This unit sees only write strobes with data, and it drives one result word.

Top module: `trig_fu`

## Requirements
- R1: A synchronous active-high reset clears the result to 0, clears the stored operand to 0 and drops every multiply in flight. After reset, an add trigger with data D and no operand write gives D.
- R2: A write to the operand port with no trigger starts no computation, and the result port does not change.
- R3: An add trigger in cycle T puts (operand + data) mod 2^32 on the result port in cycle T+1.
- R4: A multiply trigger in cycle T puts the low 32 bits of operand × data on the result port in cycle T+3. During cycles T+1 and T+2 the port still shows the older result.
- R5: Multiply triggers in consecutive cycles give their results in consecutive cycles, in trigger order.
- R6: When no operation completes, the result port holds its value.
- R7: An add triggered two cycles after a multiply completes in the same cycle as that multiply. The add, being the later trigger, takes the result port, and the multiply result is discarded.
- R8: An operand write in the same cycle as a trigger does not affect that trigger, which uses the previously stored operand. The new operand is used by later triggers.
- R9: An add and a multiply triggered in the same cycle both complete, each at its own latency.
- R10: The data written to a trigger port is not stored as the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_we | input | 1 | Write strobe of the plain operand port |
| opnd_data | input | 32 | Word written to the operand port |
| add_we | input | 1 | Write strobe of the add trigger port |
| add_data | input | 32 | Word written to the add trigger port |
| mul_we | input | 1 | Write strobe of the multiply trigger port |
| mul_data | input | 32 | Word written to the multiply trigger port |
| result | output | 32 | Most recently completed result |

## Verification
Because the add is short and the multiply is long, an add triggered two cycles after a multiply reaches the result register on the same edge as that multiply. The bench sets up this case on purpose: it triggers a multiply, waits one idle cycle and then triggers an add. It expects the add sum in the completion cycle and in the cycle after it, with no trace of the product. A second case triggers both operations in the same cycle. This checks that the two operations stay independent: the sum appears first and the product two cycles later.

// File: rtl/ttfu_pkg.sv
`timescale 1ns/1ps
package ttfu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PROD_W = 2 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic  vld;
    word_t data;
  } stage_t;

  function automatic word_t fu_sum(input word_t a, input word_t b);
    return a + b;
  endfunction

  function automatic word_t fu_prod(input word_t a, input word_t b);
    logic [PROD_W-1:0] full;
    full = {{WORD_W{1'b0}}, a} * {{WORD_W{1'b0}}, b};
    return full[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/ttfu_opnd_reg.sv
`timescale 1ns/1ps
module ttfu_opnd_reg
  import ttfu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  word_t d,
  output word_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/ttfu_mul_pipe.sv
`timescale 1ns/1ps
module ttfu_mul_pipe
  import ttfu_pkg::*;
#(
  parameter int unsigned MUL_LAT = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  fire,
  input  word_t a,
  input  word_t b,
  output logic  done,
  output word_t done_data
);
  localparam int unsigned NSTG = MUL_LAT - 1;

  stage_t stg_q [NSTG];

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= '0;
    else begin
      stg_q[0].vld  <= fire;
      stg_q[0].data <= fire ? fu_prod(a, b) : '0;
    end
  end

  for (genvar i = 1; i < NSTG; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[i] <= '0;
      else stg_q[i] <= stg_q[i-1];
    end
  end

  assign done      = stg_q[NSTG-1].vld;
  assign done_data = stg_q[NSTG-1].data;
endmodule

// File: rtl/ttfu_result_sel.sv
`timescale 1ns/1ps
module ttfu_result_sel
  import ttfu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  add_fire,
  input  word_t add_val,
  input  logic  mul_done,
  input  word_t mul_val,
  output logic  load,
  output word_t result
);
  assign load = add_fire | mul_done;

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else if (add_fire) result <= add_val;
    else if (mul_done) result <= mul_val;
  end
endmodule

// File: rtl/trig_fu.sv
`timescale 1ns/1ps
module trig_fu
  import ttfu_pkg::*;
#(
  parameter int unsigned MUL_LAT = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        opnd_we,
  input  logic [31:0] opnd_data,
  input  logic        add_we,
  input  logic [31:0] add_data,
  input  logic        mul_we,
  input  logic [31:0] mul_data,
  output logic [31:0] result
);
  word_t opnd_q;
  word_t sum_w;
  word_t mul_val;
  logic  add_fire;
  logic  mul_fire;
  logic  mul_done;
  logic  res_load;

  assign add_fire = add_we;
  assign mul_fire = mul_we;
  assign sum_w    = fu_sum(opnd_q, add_data);

  ttfu_opnd_reg u_opnd (
    .clk (clk), .rst (rst), .we (opnd_we), .d (opnd_data), .q (opnd_q)
  );

  ttfu_mul_pipe #(.MUL_LAT(MUL_LAT)) u_mul (
    .clk (clk), .rst (rst), .fire (mul_fire), .a (opnd_q), .b (mul_data),
    .done (mul_done), .done_data (mul_val)
  );

  ttfu_result_sel u_res (
    .clk (clk), .rst (rst), .add_fire (add_fire), .add_val (sum_w),
    .mul_done (mul_done), .mul_val (mul_val), .load (res_load),
    .result (result)
  );
endmodule

// File: rtl/ttfu_chk.sv
`timescale 1ns/1ps
module ttfu_chk (
  input logic        clk,
  input logic        rst,
  input logic        opnd_we,
  input logic [31:0] opnd_data,
  input logic        add_we,
  input logic [31:0] add_data,
  input logic        mul_done,
  input logic [31:0] mul_val,
  input logic        res_load,
  input logic [31:0] opnd_q,
  input logic [31:0] result
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_clear: assert (result == '0 && opnd_q == '0 && !mul_done);
    end
  end

  a_r3_add_next: assert property (@(posedge clk) disable iff (rst)
    add_we |=> result == $past(opnd_q) + $past(add_data));

  a_r4_mul_lands: assert property (@(posedge clk) disable iff (rst)
    mul_done && !add_we |=> result == $past(mul_val));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !res_load |=> $stable(result));

  a_r7_add_wins: assert property (@(posedge clk) disable iff (rst)
    add_we && mul_done |=> result != $past(mul_val) || $past(mul_val) == $past(opnd_q) + $past(add_data));

  a_r10_opnd_keep: assert property (@(posedge clk) disable iff (rst)
    !opnd_we |=> $stable(opnd_q));

  a_r8_opnd_take: assert property (@(posedge clk) disable iff (rst)
    opnd_we |=> opnd_q == $past(opnd_data));
endmodule

bind trig_fu ttfu_chk chk_i (
  .clk (clk), .rst (rst), .opnd_we (opnd_we), .opnd_data (opnd_data),
  .add_we (add_we), .add_data (add_data), .mul_done (mul_done),
  .mul_val (mul_val), .res_load (res_load), .opnd_q (opnd_q),
  .result (result)
);

// File: tb/trig_fu_tb_top.sv
`timescale 1ns/1ps
module trig_fu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opnd_we = 1'b0;
  logic [31:0] opnd_data = '0;
  logic        add_we = 1'b0;
  logic [31:0] add_data = '0;
  logic        mul_we = 1'b0;
  logic [31:0] mul_data = '0;
  logic [31:0] result;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  trig_fu dut_i (
    .clk (clk), .rst (rst), .opnd_we (opnd_we), .opnd_data (opnd_data),
    .add_we (add_we), .add_data (add_data), .mul_we (mul_we),
    .mul_data (mul_data), .result (result)
  );

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    p = 64'(a) * 64'(b);
    return p[31:0];
  endfunction

  task automatic cyc(input logic ow, input logic [31:0] ov,
                     input logic aw, input logic [31:0] av,
                     input logic mw, input logic [31:0] mv);
    opnd_we = ow; opnd_data = ov;
    add_we = aw;  add_data = av;
    mul_we = mw;  mul_data = mv;
    @(negedge clk);
    opnd_we = 1'b0; add_we = 1'b0; mul_we = 1'b0;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic chk(input string req, input logic [31:0] exp);
    n_vec++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, result, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 result after reset", 32'h0);
    cyc(0, 0, 1, 32'h5, 0, 0);
    chk("R1 operand cleared by reset", 32'h5);
  endtask

  task automatic t_opnd_only();
    cyc(1, 32'h7, 0, 0, 0, 0);
    chk("R2 operand write leaves result", 32'h5);
    idle(); idle();
    chk("R6 result holds when idle", 32'h5);
  endtask

  task automatic t_add();
    cyc(1, 32'h1000_0001, 0, 0, 0, 0);
    cyc(0, 0, 1, 32'h0000_0234, 0, 0);
    chk("R3 add next cycle", 32'h1000_0235);
    cyc(1, 32'hffff_ffff, 0, 0, 0, 0);
    cyc(0, 0, 1, 32'h2, 0, 0);
    chk("R3 add wraps", 32'h1);
  endtask

  task automatic t_mul();
    cyc(1, 32'h0001_2345, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 32'h0000_6789);
    chk("R4 mul not ready T+1", 32'h1);
    idle();
    chk("R4 mul not ready T+2", 32'h1);
    idle();
    chk("R4 mul ready T+3", ref_mul(32'h0001_2345, 32'h0000_6789));
    cyc(1, 32'hdead_beef, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 32'h1234_5679);
    idle(); idle();
    chk("R4 mul keeps low word", ref_mul(32'hdead_beef, 32'h1234_5679));
  endtask

  task automatic t_pipe();
    cyc(1, 32'h3, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 32'd10);
    cyc(0, 0, 0, 0, 1, 32'd11);
    cyc(0, 0, 0, 0, 1, 32'd12);
    chk("R5 first of burst", 32'd30);
    idle();
    chk("R5 second of burst", 32'd33);
    idle();
    chk("R5 third of burst", 32'd36);
    idle();
    chk("R6 hold after burst", 32'd36);
  endtask

  task automatic t_collide();
    cyc(1, 32'h4, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 32'h5);
    idle();
    cyc(0, 0, 1, 32'h6, 0, 0);
    chk("R7 later add wins", 32'd10);
    idle();
    chk("R7 mul result dropped", 32'd10);
  endtask

  task automatic t_same_cycle_opnd();
    cyc(1, 32'h2, 0, 0, 0, 0);
    cyc(1, 32'h9, 1, 32'h3, 0, 0);
    chk("R8 trigger uses old operand", 32'd5);
    cyc(0, 0, 1, 32'h1, 0, 0);
    chk("R8 new operand for later trigger", 32'd10);
  endtask

  task automatic t_both();
    cyc(1, 32'h3, 0, 0, 0, 0);
    cyc(0, 0, 1, 32'h4, 1, 32'h5);
    chk("R9 add of pair", 32'd7);
    idle();
    chk("R9 hold between", 32'd7);
    idle();
    chk("R9 mul of pair", 32'd15);
  endtask

  task automatic t_trig_no_store();
    cyc(1, 32'h6, 0, 0, 0, 0);
    cyc(0, 0, 1, 32'd100, 0, 0);
    chk("R10 add with 100", 32'd106);
    cyc(0, 0, 1, 32'd1, 0, 0);
    chk("R10 trigger data not stored", 32'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_opnd_only();
    t_add();
    t_mul();
    t_pipe();
    t_collide();
    t_same_cycle_opnd();
    t_both();
    t_trig_no_store();
    rst = 1'b1;
    cyc(1, 32'h55, 0, 0, 1, 32'h2);
    rst = 1'b0;
    idle(); idle();
    chk("R1 reset drops pending mul", 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule